// File: doc/BRIEF.md
# Embedded-Clock Word Aligner and Lock Detector

This block sits behind the clock-recovery stage of a serial receive link. One recovered bit enters per clock. The transmitter sends 12-bit frames. Each frame starts with a clock-bit pair, a 1 followed at once by a 0. Ten data bits follow, least significant bit first. The block finds the offset inside the 12-bit period where that pair repeats. It refuses to settle while the stream allows more than one such offset. Once it locks, it unpacks each frame into a parallel word with a one-cycle strobe. It marks the first word after every lock acquisition, so that downstream logic can discard the words that arrived just before a drop-out. The lock indicator is active low.

The state machine has three states:
- `ST_HUNT`: the candidate search.
- `ST_LOCKED`: word delivery and loss watch.
- `ST_DOWN`: power-down.

The transitions are:
- `ST_HUNT`→`ST_LOCKED` on a single confirmed candidate.
- `ST_LOCKED`→`ST_HUNT` on the fourth bad clock-bit pair in a row.
- `ST_HUNT` or `ST_LOCKED`→`ST_DOWN` when receive-enable and power-up are both low.
- `ST_DOWN`→`ST_HUNT` when either of them returns high.

The pad drivers sit outside the block. The block gives them an output enable for the word group and another for the lock pin. The word outputs read zero whenever their enable is low.

Top module: `ecd_lock_detector`

## Requirements
- R1: After reset the block is in `ST_HUNT`. In that state `lock_n_o`=1, `lock_oe_o`=1 (with either enable input high), `word_oe_o`=0, and `word_o`, `word_stb_o` and `first_word_o` are all 0.
- R2: The search tracks 12 candidate offsets. An offset is dropped the first time its pair (previous bit 1, current bit 0) fails. Lock is granted only at the end of a 12-bit period, once 4 full periods have been checked, and only when exactly one candidate remains. Lock is therefore never granted within 3 frames of the hunt starting.
- R3: While two or more offsets keep fitting the stream (for example, repeated data 0x001), `lock_n_o` stays 1. Once the data changes so that only one offset remains, lock is granted.
- R4: In `ST_LOCKED`, a bad clock-bit pair increments a counter and a good pair clears it. Fewer than 4 bad pairs in a row never drop lock.
- R5: The fourth consecutive bad pair returns the block to `ST_HUNT`, so `lock_n_o` goes to 1 and `word_oe_o` goes to 0. The hunt then restarts and can lock again.
- R6: The frame is bit 1, then bit 0, then data bits d0 to d9. `word_o[i]` is di. `word_stb_o` pulses for one cycle, in the cycle after d9 was sampled.
- R7: `first_word_o` is 1 with the first strobe after each lock acquisition and 0 with every later strobe.
- R8: With `rx_en_i`=0 and `pwr_up_i`=1, `word_oe_o`=0 and the word outputs are quiet. `lock_oe_o` stays 1 and `lock_n_o` keeps showing the true lock state.
- R9: With `rx_en_i`=0 and `pwr_up_i`=0, `lock_oe_o`=0 at once. The next edge enters `ST_DOWN`, which discards any lock. On exit the block hunts from the start.
- R10: When no offset survives a full 4-period window, the candidate set refills and the search continues without outside help.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_bit_i | input | 1 | Serial bit sampled this cycle |
| rx_en_i | input | 1 | Receive enable; low hides the word group |
| pwr_up_i | input | 1 | Low together with rx_en_i selects power-down |
| word_o | output | WORD_W | Recovered data word, d0 in bit 0 |
| word_stb_o | output | 1 | One-cycle pulse per recovered word |
| first_word_o | output | 1 | Set with the first word after a lock acquisition |
| word_oe_o | output | 1 | Pad enable for word_o, word_stb_o, first_word_o |
| lock_n_o | output | 1 | Lock indicator, 0 = locked |
| lock_oe_o | output | 1 | Pad enable for lock_n_o |

## Verification
The assertions assume that exactly one new bit is presented in every clock cycle, with no idle or stalled bit slots. They also assume that the enable inputs change only between clock edges. The checks on lock hold and loss further assume that no power-down request arrives in the middle of a bad-pair run. The bench meets these assumptions by driving every input on the falling edge and feeding a continuous bit stream, using zero fill where no frame is sent. It enters power-down only in a dedicated test, after the loss tests have finished.

// File: rtl/ecdl_pkg.sv
`timescale 1ns/1ps
package ecdl_pkg;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_LOCKED = 2'd1,
        ST_DOWN   = 2'd2
    } lk_state_e;

endpackage

// File: rtl/ecdl_phase_ctr.sv
`timescale 1ns/1ps
// Free-running bit position inside the 12-bit period, plus the pair test
// on the previous and current bit.
module ecdl_phase_ctr #(
    parameter int FRAME_W = 12,
    localparam int PW = $clog2(FRAME_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_i,
    output logic [PW-1:0] phase_o,
    output logic          wrap_o,
    output logic          pair_ok_o
);
    logic [PW-1:0] phase_q;
    logic          prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            phase_q <= (phase_q == PW'(FRAME_W - 1)) ? '0 : phase_q + 1'b1;
            prev_q  <= bit_i;
        end
    end

    assign phase_o   = phase_q;
    assign wrap_o    = (phase_q == PW'(FRAME_W - 1));
    assign pair_ok_o = prev_q & ~bit_i;

    // R6: the period is exactly FRAME_W bits long
    p_phase_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PW'(FRAME_W - 1)) |=> (phase_q == '0));

endmodule

// File: rtl/ecdl_cand_track.sv
`timescale 1ns/1ps
// Candidate-offset mask with confirmation window and refill.
module ecdl_cand_track #(
    parameter int FRAME_W = 12,
    parameter int CONFIRM_PERIODS = 4,
    localparam int PW = $clog2(FRAME_W),
    localparam int CW = $clog2(CONFIRM_PERIODS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hunt_i,
    input  logic [PW-1:0] phase_i,
    input  logic          wrap_i,
    input  logic          pair_ok_i,
    output logic          found_o,
    output logic [PW-1:0] found_off_o
);
    logic [FRAME_W-1:0] mask_q, mask_c;
    logic               armed_q;
    logic [CW-1:0]      per_q, per_c;
    logic               refill_c, found_c;

    always_comb begin
        mask_c   = mask_q;
        per_c    = per_q;
        refill_c = 1'b0;
        found_c  = 1'b0;
        if (!pair_ok_i) begin
            mask_c[phase_i] = 1'b0;
        end
        if (wrap_i) begin
            if (!armed_q) begin
                refill_c = 1'b1;
            end else begin
                per_c = (per_q == CW'(CONFIRM_PERIODS)) ? per_q : per_q + 1'b1;
                if (per_c == CW'(CONFIRM_PERIODS)) begin
                    if ($countones(mask_c) == 1) begin
                        found_c = 1'b1;
                    end else if (mask_c == '0) begin
                        refill_c = 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        found_off_o = '0;
        for (int i = 0; i < FRAME_W; i++) begin
            if (mask_c[i]) begin
                found_off_o = PW'(i);
            end
        end
    end

    assign found_o = hunt_i & found_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '1;
            armed_q <= 1'b0;
            per_q   <= '0;
        end else if (!hunt_i) begin
            mask_q  <= '1;
            armed_q <= 1'b0;
            per_q   <= '0;
        end else if (refill_c) begin
            mask_q  <= '1;
            armed_q <= 1'b1;
            per_q   <= '0;
        end else begin
            mask_q  <= mask_c;
            per_q   <= per_c;
        end
    end

    // R3: without a refill the candidate set can only shrink
    p_mask_shrink_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hunt_i && !refill_c) |=> ((mask_q & ~$past(mask_q)) == '0));

endmodule

// File: rtl/ecdl_word_asm.sv
`timescale 1ns/1ps
// Word assembly relative to the locked offset.
module ecdl_word_asm #(
    parameter int WORD_W = 10,
    localparam int FRAME_W = WORD_W + 2,
    localparam int PW = $clog2(FRAME_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_i,
    input  logic [PW-1:0]     phase_i,
    input  logic [PW-1:0]     off_i,
    input  logic              run_i,
    output logic              at_pair_o,
    output logic              done_o,
    output logic [WORD_W-1:0] word_o,
    output logic              stb_o
);
    logic [PW-1:0]     rel_c;
    logic [WORD_W-1:0] sh_q, word_q;
    logic              stb_q;

    always_comb begin
        if (phase_i >= off_i) begin
            rel_c = phase_i - off_i;
        end else begin
            rel_c = phase_i + PW'(FRAME_W) - off_i;
        end
    end

    assign at_pair_o = run_i && (rel_c == '0);
    assign done_o    = run_i && (rel_c == PW'(WORD_W));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            word_q <= '0;
            stb_q  <= 1'b0;
        end else begin
            sh_q  <= {bit_i, sh_q[WORD_W-1:1]};
            stb_q <= done_o;
            if (done_o) begin
                word_q <= {bit_i, sh_q[WORD_W-1:1]};
            end
        end
    end

    assign word_o = word_q;
    assign stb_o  = stb_q;

    // R6: a strobe lasts exactly one cycle
    p_stb_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stb_q |=> !stb_q);

endmodule

// File: rtl/ecd_lock_detector.sv
`timescale 1ns/1ps
module ecd_lock_detector
    import ecdl_pkg::*;
#(
    parameter int WORD_W = 10,
    parameter int CONFIRM_PERIODS = 4,
    parameter int LOSS_LIMIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_bit_i,
    input  logic              rx_en_i,
    input  logic              pwr_up_i,
    output logic [WORD_W-1:0] word_o,
    output logic              word_stb_o,
    output logic              first_word_o,
    output logic              word_oe_o,
    output logic              lock_n_o,
    output logic              lock_oe_o
);
    localparam int FRAME_W = WORD_W + 2;
    localparam int PW      = $clog2(FRAME_W);
    localparam int LW      = $clog2(LOSS_LIMIT + 1);

    lk_state_e         state_q, state_c;
    logic [PW-1:0]     phase, found_off, off_q;
    logic              wrap, pair_ok, found;
    logic              at_pair, done, asm_stb;
    logic [WORD_W-1:0] asm_word;
    logic [LW-1:0]     bad_q;
    logic              first_pend_q, first_q;
    logic              down_req, loss_c, locked;

    ecdl_phase_ctr #(.FRAME_W(FRAME_W)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_i     (rx_bit_i),
        .phase_o   (phase),
        .wrap_o    (wrap),
        .pair_ok_o (pair_ok)
    );

    ecdl_cand_track #(.FRAME_W(FRAME_W), .CONFIRM_PERIODS(CONFIRM_PERIODS)) u_cand (
        .clk         (clk),
        .rst_n       (rst_n),
        .hunt_i      (state_q == ST_HUNT),
        .phase_i     (phase),
        .wrap_i      (wrap),
        .pair_ok_i   (pair_ok),
        .found_o     (found),
        .found_off_o (found_off)
    );

    ecdl_word_asm #(.WORD_W(WORD_W)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_i     (rx_bit_i),
        .phase_i   (phase),
        .off_i     (off_q),
        .run_i     (locked),
        .at_pair_o (at_pair),
        .done_o    (done),
        .word_o    (asm_word),
        .stb_o     (asm_stb)
    );

    assign down_req = !rx_en_i && !pwr_up_i;
    assign loss_c   = at_pair && !pair_ok && (bad_q == LW'(LOSS_LIMIT - 1));

    // next state
    always_comb begin
        state_c = state_q;
        unique case (state_q)
            ST_DOWN:   if (!down_req) state_c = ST_HUNT;
            ST_HUNT:   if (down_req) state_c = ST_DOWN;
                       else if (found) state_c = ST_LOCKED;
            ST_LOCKED: if (down_req) state_c = ST_DOWN;
                       else if (loss_c) state_c = ST_HUNT;
            default:   state_c = ST_HUNT;
        endcase
    end

    // state register and per-lock bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_HUNT;
            off_q        <= '0;
            bad_q        <= '0;
            first_pend_q <= 1'b0;
            first_q      <= 1'b0;
        end else begin
            state_q <= state_c;
            if (state_q == ST_HUNT && found) begin
                off_q <= found_off;
            end
            if (state_q != ST_LOCKED) begin
                bad_q <= '0;
            end else if (at_pair) begin
                bad_q <= pair_ok ? '0 : bad_q + 1'b1;
            end
            first_q <= done && first_pend_q;
            if (state_q == ST_HUNT && state_c == ST_LOCKED) begin
                first_pend_q <= 1'b1;
            end else if (done) begin
                first_pend_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        locked       = (state_q == ST_LOCKED);
        lock_oe_o    = !down_req;
        lock_n_o     = !locked;
        word_oe_o    = locked && rx_en_i;
        word_o       = word_oe_o ? asm_word : '0;
        word_stb_o   = word_oe_o && asm_stb;
        first_word_o = word_oe_o && asm_stb && first_q;
    end

    // R2: lock is only granted on a period boundary
    p_lock_on_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(phase) == PW'(FRAME_W - 1)));

    // R4: short bad runs never drop lock
    p_hold_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED && !down_req && bad_q != LW'(LOSS_LIMIT - 1))
        |=> (state_q == ST_LOCKED));

    // R9: a power-down request is honoured on the next edge
    p_enter_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
        down_req |=> (state_q == ST_DOWN));

    // R7: the first-word flag only travels with a strobe
    p_first_with_stb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        first_q |-> asm_stb);

endmodule

// File: tb/ecd_lock_detector_tb.sv
`timescale 1ns/1ps
module ecd_lock_detector_tb;
    localparam int WORD_W = 10;

    logic clk = 1'b0, rst_n = 1'b0, rx_bit = 1'b0, rx_en = 1'b1, pwr_up = 1'b1;
    logic [WORD_W-1:0] word;
    logic word_stb, first_word, word_oe, lock_n, lock_oe;

    int checks = 0, fails = 0;
    logic [WORD_W-1:0] last_sent = '0;
    bit last_d9 = 1'b0;
    int since_lock = 0;
    int stb_seen = 0;
    int fidx = 0;

    // {skew[3:0], mode[1:0], expect_lock}
    localparam logic [6:0] SCEN [6] = '{
        {4'd0,  2'd0, 1'b1},
        {4'd3,  2'd0, 1'b1},
        {4'd7,  2'd0, 1'b1},
        {4'd10, 2'd0, 1'b1},
        {4'd5,  2'd1, 1'b0},
        {4'd2,  2'd2, 1'b1}
    };

    ecd_lock_detector #(.WORD_W(WORD_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_bit_i     (rx_bit),
        .rx_en_i      (rx_en),
        .pwr_up_i     (pwr_up),
        .word_o       (word),
        .word_stb_o   (word_stb),
        .first_word_o (first_word),
        .word_oe_o    (word_oe),
        .lock_n_o     (lock_n),
        .lock_oe_o    (lock_oe)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic logic [WORD_W-1:0] pat(input int mode, input int f);
        if (mode == 1) return 10'h001;
        if (mode == 2) return '0;
        case (f % 4)
            0: return 10'h000;
            1: return 10'h3FF;
            2: return 10'h155;
            default: return 10'h2AA;
        endcase
    endfunction

    task automatic put_bit(input logic b, input bit is_d9);
        @(negedge clk);
        rx_bit  = b;
        last_d9 = is_d9;
    endtask

    task automatic send_frame(input logic [WORD_W-1:0] d, input logic c1, input logic c0);
        put_bit(c1, 1'b0);
        put_bit(c0, 1'b0);
        for (int i = 0; i < WORD_W; i++) begin
            put_bit(d[i], i == WORD_W - 1);
            if (i == WORD_W - 1) last_sent = d;
        end
    endtask

    task automatic send_frames(input int mode, input int n);
        for (int k = 0; k < n; k++) begin
            send_frame(pat(mode, fidx), 1'b1, 1'b0);
            fidx++;
        end
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rx_bit = 1'b0;
        rx_en = 1'b1;
        pwr_up = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // word monitor
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (!(lock_oe && !lock_n)) since_lock = 0;
            if (word_oe && word_stb) begin
                stb_seen++;
                chk(word == last_sent, "R6 word value", int'(word), int'(last_sent));
                chk(last_d9, "R6 strobe follows d9", int'(last_d9), 1);
                chk(first_word == (since_lock == 0), "R7 first-word flag",
                    int'(first_word), int'(since_lock == 0));
                since_lock++;
            end
        end
    end

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // table of scenarios
        for (int s = 0; s < 6; s++) begin
            int skew;
            int mode;
            bit exp_lock;
            skew = int'(SCEN[s][6:3]);
            mode = int'(SCEN[s][2:1]);
            exp_lock = SCEN[s][0];
            do_reset();
            settle();
            chk(lock_oe && lock_n, "R1 reset lock indicator", int'(lock_n), 1);
            chk(!word_oe && !word_stb && !first_word && word == '0,
                "R1 reset word group quiet", int'(word_oe), 0);
            for (int k = 0; k < skew; k++) put_bit(1'b0, 1'b0);
            stb_seen = 0;
            send_frames(mode, 3);
            settle();
            chk(lock_n, "R2 no lock within 3 frames", int'(lock_n), 1);
            send_frames(mode, 7);
            settle();
            chk(lock_n == !exp_lock, exp_lock ? "R2 lock on single offset" : "R3 ambiguous stream",
                int'(lock_n), int'(!exp_lock));
            if (exp_lock) chk(stb_seen > 0, "R6 words delivered", stb_seen, 1);
            else chk(!word_oe, "R3 words hidden while hunting", int'(word_oe), 0);
        end

        // R3: ambiguity resolves once data varies
        do_reset();
        send_frames(1, 8);
        settle();
        chk(lock_n, "R3 two offsets keep lock off", int'(lock_n), 1);
        send_frames(0, 8);
        settle();
        chk(!lock_n, "R3 lock after ambiguity clears", int'(lock_n), 0);

        // R4 / R5: bad pair runs
        send_frame('0, 1'b0, 1'b0);
        send_frame('0, 1'b0, 1'b0);
        send_frame('0, 1'b0, 1'b0);
        settle();
        chk(!lock_n, "R4 three bad pairs keep lock", int'(lock_n), 0);
        send_frames(0, 2);
        send_frame('0, 1'b0, 1'b0);
        send_frame('0, 1'b0, 1'b0);
        send_frame('0, 1'b0, 1'b0);
        settle();
        chk(!lock_n, "R4 counter cleared by good pair", int'(lock_n), 0);
        send_frame('0, 1'b0, 1'b0);
        send_frame('0, 1'b0, 1'b0);
        send_frame('0, 1'b0, 1'b0);
        send_frame('0, 1'b0, 1'b0);
        settle();
        chk(lock_n, "R5 fourth bad pair drops lock", int'(lock_n), 1);
        chk(!word_oe && !word_stb, "R5 word group disabled after loss", int'(word_oe), 0);
        send_frames(0, 8);
        settle();
        chk(!lock_n, "R5 relock after loss", int'(lock_n), 0);

        // R8: receive disabled while locked
        @(negedge clk);
        rx_en = 1'b0;
        send_frames(0, 2);
        settle();
        chk(!word_oe && !word_stb && word == '0, "R8 word group hidden", int'(word_oe), 0);
        chk(lock_oe && !lock_n, "R8 lock still shown", int'(lock_n), 0);
        @(negedge clk);
        rx_en = 1'b1;
        settle();
        chk(word_oe, "R8 word group back", int'(word_oe), 1);

        // R9: power-down
        @(negedge clk);
        rx_en = 1'b0;
        pwr_up = 1'b0;
        #1;
        chk(!lock_oe && !word_oe, "R9 all outputs released", int'(lock_oe), 0);
        send_frames(0, 2);
        @(negedge clk);
        pwr_up = 1'b1;
        settle();
        chk(lock_oe && lock_n, "R9 hunt restarts after power-down", int'(lock_n), 1);
        @(negedge clk);
        rx_en = 1'b1;
        send_frames(0, 8);
        settle();
        chk(!lock_n, "R9 relock after power-down", int'(lock_n), 0);

        // R10: empty candidate set refills
        do_reset();
        for (int k = 0; k < 60; k++) put_bit(1'b0, 1'b0);
        settle();
        chk(lock_n, "R10 no lock on flat stream", int'(lock_n), 1);
        send_frames(0, 10);
        settle();
        chk(!lock_n, "R10 lock after refill", int'(lock_n), 0);

        // R1: reset while locked
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(lock_n && !word_oe, "R1 reset clears lock", int'(lock_n), 1);
        @(negedge clk);
        rst_n = 1'b1;

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule